// File: doc/BRIEF.md
# Deep-Idle Power Sequencer

This block moves a device between full operation and a deep-idle state. In deep idle the core voltage rails and the PLLs are off, but the bus interface stays powered so that it can still see bus writes. The host asks for entry with a one-cycle request pulse. The request is honoured only when both the graphics engine and the audio engine report idle. An honoured request is acknowledged with an interrupt pulse. The block then walks through nine ordered steps. Each step fires its own one-cycle start strobe and then waits for a done handshake before the next step begins. The work behind each step (memory save, PHY low-power, firmware actions) lies outside the block and is represented only by that handshake.

A range monitor watches bus writes against a programmable inclusive address window. After the doorbell-enable step, the monitor belongs to the always-on bus side. In deep idle, an in-window write raises a wake interrupt, turns the rails back on and starts the exit walk. Audio activity in deep idle does the same. Exit replays the completed steps in reverse order and has no link-retraining step.

A doorbell write during entry is latched and aborts the entry once the step in flight completes. Audio activity during entry aborts it the same way. A step whose done never arrives leads to an error state that restores full power.

Top module: `deep_idle_seq`

## Requirements
- R1: After reset, `state` is 0 (active), `rail_on` and `pll_on` are 1, `db_aon_own` is 0, and `step_go` and `ack_irq` are 0.
- R2: A request pulse while `gfx_idle` is low produces no acknowledge and leaves `state` at 0.
- R3: A request pulse while both engines are idle gives a one-cycle `ack_irq` in the next cycle, with `state` 1 (entering). The first step strobe comes after the acknowledge.
- R4: A request pulse while `aud_idle` is low is refused in the same silent way, even when the graphics engine is idle.
- R5: The entry steps fire in this order on the `step_go` bits: 0 save frame buffer, 1 thermal PHY low power, 2 display PLL low power, 3 doorbell monitor enable, 4 D-state bypass, 5 entry event, 6 interrupt mask, 7 PLL gate, 8 rail off. Each strobe is one cycle with `step_exit` 0, at most one bit is high at a time, and a step starts only after the previous done.
- R6: If `dpll_en` is low when the request is accepted, step 2 is skipped on both entry and exit.
- R7: In deep idle (`state` 2), `pll_on` is 0 (it falls when step 7 completes), `rail_on` is 0 (it falls when step 8 completes), and `db_aon_own` is 1 (it rises when step 3 completes).
- R8: In deep idle, a bus write with `db_lo <= bus_addr <= db_hi` gives a one-cycle `wake_irq`, sets `rail_on` to 1 and moves `state` to 3 (exiting). A write outside the window is ignored.
- R9: In deep idle, `aud_idle` going low also wakes the block, with the same `wake_irq`, `rail_on` and state change.
- R10: Exit strobes the steps from 8 down to 0 with `step_exit` 1. `pll_on` returns at exit step 7 and `db_aon_own` clears at exit step 3. After step 0, `state` is 0.
- R11: An in-window write during entry is latched. When the current step's done arrives, the entry is abandoned, and exit strobes run from that step down to 0.
- R12: If no done arrives within `TMO_CYC` cycles of waiting, `state` becomes 4 (error) with `rail_on` and `pll_on` at 1. It returns to 0 after another `TMO_CYC` cycles.
- R13: A request pulse while `state` is not 0 is ignored: there is no acknowledge and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | One-cycle deep-idle entry request |
| gfx_idle | input | 1 | Graphics engine idle |
| aud_idle | input | 1 | Audio engine idle |
| dpll_en | input | 1 | Display PLL in use; selects step 2 |
| bus_wr | input | 1 | Bus write valid |
| bus_addr | input | AW | Bus write address |
| db_lo | input | AW | Doorbell window low bound (inclusive) |
| db_hi | input | AW | Doorbell window high bound (inclusive) |
| step_done | input | 1 | Done handshake for the step in flight |
| ack_irq | output | 1 | Entry acknowledge interrupt pulse |
| step_go | output | 9 | One-hot step start strobes |
| step_exit | output | 1 | Strobes belong to the exit walk |
| rail_on | output | 1 | Core voltage rail enable |
| pll_on | output | 1 | PLL enable |
| db_aon_own | output | 1 | Doorbell monitor owned by the always-on side |
| wake_irq | output | 1 | Wake interrupt pulse |
| state | output | 3 | 0 active, 1 entering, 2 deep idle, 3 exiting, 4 error |

## Verification
Entry is attempted with graphics busy, with audio busy and with both idle, which separates the idle gate from the acknowledge path. Full walks are run with the display PLL used and unused. These compare strobe orders that differ only at step 2, and they check that exit mirrors entry. The block is woken from deep idle in two ways: by an in-window write at the upper bound (just after an ignored write past it), and by audio activity. Finally, a doorbell that arrives mid-entry and a step that never finishes show the abort walk apart from the timeout recovery.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NSTEP = 9;
  localparam int IW = $clog2(NSTEP);
  typedef logic [IW-1:0] stp_idx_t;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_ENTER  = 3'd1,
    ST_DEEP   = 3'd2,
    ST_EXIT   = 3'd3,
    ST_ERROR  = 3'd4
  } dis_state_e;

  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_GO   = 2'd1,
    PH_WAIT = 2'd2
  } dis_phase_e;

  // step positions whose completion moves an output
  localparam stp_idx_t STP_FIRST = stp_idx_t'(0);
  localparam stp_idx_t STP_DPLL  = stp_idx_t'(2);
  localparam stp_idx_t STP_DBELL = stp_idx_t'(3);
  localparam stp_idx_t STP_PLL   = stp_idx_t'(7);
  localparam stp_idx_t STP_RAIL  = stp_idx_t'(NSTEP - 1);
endpackage

// File: rtl/dis_rst_sync.sv
module dis_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dis_doorbell.sv
module dis_doorbell #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] db_lo,
  input  logic [AW-1:0] db_hi,
  input  logic          collect,   // entry walk in progress
  input  logic          armed,     // owned by always-on side
  output logic          pend,
  output logic          wake
);
  logic hit;
  logic pend_q, pend_d;

  assign hit = bus_wr && (bus_addr >= db_lo) && (bus_addr <= db_hi);

  always_comb begin
    pend_d = pend_q;
    if (!collect)  pend_d = 1'b0;
    else if (hit)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q || (collect && hit);
  assign wake = armed && hit;
endmodule

// File: rtl/dis_timer.sv
module dis_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (run && !hit) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dis_fsm.sv
module dis_fsm
  import dis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_req,
  input  logic             gfx_idle,
  input  logic             aud_idle,
  input  logic             dpll_en,
  input  logic             step_done,
  input  logic             tmo_hit,
  input  logic             db_pend,
  input  logic             db_wake,
  output dis_state_e       st,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic [NSTEP-1:0] step_go,
  output logic             step_exit,
  output logic             ack_irq,
  output logic             wake_irq,
  output logic             rail_on,
  output logic             pll_on,
  output logic             db_armed
);
  dis_state_e st_q, st_d;
  dis_phase_e ph_q, ph_d;
  stp_idx_t   idx_q, idx_d;
  logic       dp_q, dp_d;
  logic       ack_q, ack_d, wake_q, wake_d;
  logic       rail_q, rail_d, pll_q, pll_d, arm_q, arm_d;
  logic       walking, abort;

  function automatic stp_idx_t step_up(input stp_idx_t i, input logic dp);
    stp_idx_t r;
    r = i + stp_idx_t'(1);
    if (r == STP_DPLL && !dp) r = i + stp_idx_t'(2);
    return r;
  endfunction

  function automatic stp_idx_t step_dn(input stp_idx_t i, input logic dp);
    stp_idx_t r;
    r = i - stp_idx_t'(1);
    if (r == STP_DPLL && !dp) r = i - stp_idx_t'(2);
    return r;
  endfunction

  assign walking = (st_q == ST_ENTER) || (st_q == ST_EXIT);
  assign abort   = db_pend || !aud_idle;

  always_comb begin
    st_d = st_q; ph_d = ph_q; idx_d = idx_q; dp_d = dp_q;
    rail_d = rail_q; pll_d = pll_q; arm_d = arm_q;
    ack_d = 1'b0; wake_d = 1'b0;
    case (st_q)
      ST_ACTIVE: begin
        if (entry_req && gfx_idle && aud_idle) begin
          st_d = ST_ENTER; ph_d = PH_GAP; idx_d = STP_FIRST;
          dp_d = dpll_en; ack_d = 1'b1;
        end
      end
      ST_ENTER, ST_EXIT: begin
        case (ph_q)
          PH_GAP: ph_d = PH_GO;
          PH_GO:  ph_d = PH_WAIT;
          default: begin
            if (step_done) begin
              ph_d = PH_GAP;
              if (st_q == ST_ENTER) begin
                if (idx_q == STP_DBELL) arm_d = 1'b1;
                if (idx_q == STP_PLL)   pll_d = 1'b0;
                if (idx_q == STP_RAIL)  rail_d = 1'b0;
                if (abort) begin
                  st_d = ST_EXIT; rail_d = 1'b1;
                end else if (idx_q == STP_RAIL) begin
                  st_d = ST_DEEP;
                end else begin
                  idx_d = step_up(idx_q, dp_q);
                end
              end else begin
                if (idx_q == STP_DBELL) arm_d = 1'b0;
                if (idx_q == STP_PLL)   pll_d = 1'b1;
                if (idx_q == STP_FIRST) st_d = ST_ACTIVE;
                else                    idx_d = step_dn(idx_q, dp_q);
              end
            end else if (tmo_hit) begin
              st_d = ST_ERROR; ph_d = PH_GAP;
              rail_d = 1'b1; pll_d = 1'b1; arm_d = 1'b0;
            end
          end
        endcase
      end
      ST_DEEP: begin
        if (db_wake || !aud_idle) begin
          st_d = ST_EXIT; ph_d = PH_GAP; rail_d = 1'b1; wake_d = 1'b1;
        end
      end
      default: begin
        if (tmo_hit) st_d = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ACTIVE; ph_q <= PH_GAP; idx_q <= STP_FIRST; dp_q <= 1'b0;
      ack_q <= 1'b0; wake_q <= 1'b0;
      rail_q <= 1'b1; pll_q <= 1'b1; arm_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; idx_q <= idx_d; dp_q <= dp_d;
      ack_q <= ack_d; wake_q <= wake_d;
      rail_q <= rail_d; pll_q <= pll_d; arm_q <= arm_d;
    end
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_go
    assign step_go[g] = walking && (ph_q == PH_GO) && (idx_q == stp_idx_t'(g));
  end

  assign tmr_clr   = (ph_q == PH_GO) || (st_d != st_q);
  assign tmr_run   = (st_q == ST_ERROR) || (walking && ph_q == PH_WAIT);
  assign st        = st_q;
  assign step_exit = (st_q == ST_EXIT);
  assign ack_irq   = ack_q;
  assign wake_irq  = wake_q;
  assign rail_on   = rail_q;
  assign pll_on    = pll_q;
  assign db_armed  = arm_q;
endmodule

// File: rtl/deep_idle_seq.sv
module deep_idle_seq
  import dis_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TMO_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_req,
  input  logic             gfx_idle,
  input  logic             aud_idle,
  input  logic             dpll_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [AW-1:0]    db_lo,
  input  logic [AW-1:0]    db_hi,
  input  logic             step_done,
  output logic             ack_irq,
  output logic [NSTEP-1:0] step_go,
  output logic             step_exit,
  output logic             rail_on,
  output logic             pll_on,
  output logic             db_aon_own,
  output logic             wake_irq,
  output logic [2:0]       state
);
  logic       srst_n;
  logic       tmr_clr, tmr_run, tmo_hit;
  logic       db_pend, db_wake, db_armed;
  dis_state_e st;

  dis_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  dis_doorbell #(.AW(AW)) u_db (
    .clk(clk), .rst_n(srst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .db_lo(db_lo), .db_hi(db_hi), .collect(st == ST_ENTER),
    .armed(db_armed), .pend(db_pend), .wake(db_wake)
  );

  dis_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(srst_n), .clr(tmr_clr), .run(tmr_run), .hit(tmo_hit)
  );

  dis_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .entry_req(entry_req), .gfx_idle(gfx_idle),
    .aud_idle(aud_idle), .dpll_en(dpll_en), .step_done(step_done),
    .tmo_hit(tmo_hit), .db_pend(db_pend), .db_wake(db_wake), .st(st),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run), .step_go(step_go),
    .step_exit(step_exit), .ack_irq(ack_irq), .wake_irq(wake_irq),
    .rail_on(rail_on), .pll_on(pll_on), .db_armed(db_armed)
  );

  assign db_aon_own = db_armed;
  assign state      = st;
endmodule

// File: rtl/dis_chk.sv
module dis_chk
  import dis_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             entry_req,
  input logic             gfx_idle,
  input logic             aud_idle,
  input logic             ack_irq,
  input logic [NSTEP-1:0] step_go,
  input logic             step_exit,
  input logic             rail_on,
  input logic             pll_on,
  input logic             db_aon_own,
  input logic             wake_irq,
  input logic [2:0]       state
);
  // R3
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |-> state == 3'd1);
  // R4
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |-> ($past(gfx_idle) && $past(aud_idle)));
  // R5
  go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_go));
  // R5
  enter_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |-> !step_exit);
  // R7
  deep_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2) |-> (!rail_on && !pll_on && db_aon_own));
  // R8
  wake_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (rail_on && state == 3'd3));
  // R12
  err_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4) |-> (rail_on && pll_on && !db_aon_own));
  // R13
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && state != 3'd0) |=> !ack_irq);
endmodule

bind deep_idle_seq dis_chk u_chk (
  .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .gfx_idle(gfx_idle),
  .aud_idle(aud_idle), .ack_irq(ack_irq), .step_go(step_go),
  .step_exit(step_exit), .rail_on(rail_on), .pll_on(pll_on),
  .db_aon_own(db_aon_own), .wake_irq(wake_irq), .state(state)
);

// File: tb/tb_deep_idle_seq.sv
`timescale 1ns/1ps
module tb_deep_idle_seq;
  localparam int AW = 16;
  localparam int TMO = 16;
  localparam int NS = dis_pkg::NSTEP;

  logic clk, rst_n, entry_req, gfx_idle, aud_idle, dpll_en, bus_wr, step_done;
  logic [AW-1:0] bus_addr, db_lo, db_hi;
  logic ack_irq, step_exit, rail_on, pll_on, db_aon_own, wake_irq;
  logic [NS-1:0] step_go;
  logic [2:0] state;

  int compared = 0, mismatched = 0;
  int q_idx[$];
  bit q_ex[$];
  int dly = 0;
  bit hang = 0;
  bit done_flag = 0;

  deep_idle_seq #(.AW(AW), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .gfx_idle(gfx_idle),
    .aud_idle(aud_idle), .dpll_en(dpll_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .db_lo(db_lo), .db_hi(db_hi), .step_done(step_done),
    .ack_irq(ack_irq), .step_go(step_go), .step_exit(step_exit),
    .rail_on(rail_on), .pll_on(pll_on), .db_aon_own(db_aon_own),
    .wake_irq(wake_irq), .state(state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int idx, input bit ex);
    q_idx.push_back(idx);
    q_ex.push_back(ex);
  endtask

  task automatic pulse_req(output int ackd);
    entry_req = 1'b1;
    @(negedge clk);
    ackd = ack_irq;
    entry_req = 1'b0;
  endtask

  task automatic wait_st(input int s, input int maxc, input string tag);
    int n = 0;
    while (state != s && n < maxc) begin
      @(negedge clk);
      n++;
    end
    check(tag, state, s);
  endtask

  task automatic db_write(input logic [AW-1:0] a);
    bus_addr = a;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // scoreboard monitor and done responder (R5, R10)
  always @(negedge clk) begin
    int got;
    step_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0 && !hang) step_done = 1'b1;
    end
    if (step_go != '0) begin
      got = -1;
      for (int i = 0; i < NS; i++) if (step_go[i]) got = i;
      check("R5 strobe one-hot", $countones(step_go), 1);
      if (q_idx.size() == 0) begin
        check("R5 unexpected strobe", got, -1);
      end else begin
        int ei;
        bit ee;
        ei = q_idx.pop_front();
        ee = q_ex.pop_front();
        check(ee ? "R10 exit step index" : "R5 entry step index", got, ei);
        check("R10 step direction", step_exit, ee);
      end
      dly = 3;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int a;
    rst_n = 1'b0; entry_req = 1'b0; gfx_idle = 1'b1; aud_idle = 1'b1;
    dpll_en = 1'b1; bus_wr = 1'b0; bus_addr = '0; step_done = 1'b0;
    db_lo = 16'h0100; db_hi = 16'h01FF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    check("R1 state", state, 0);
    check("R1 rail_on", rail_on, 1);
    check("R1 pll_on", pll_on, 1);
    check("R1 owner", db_aon_own, 0);
    check("R1 step_go", step_go, 0);
    check("R1 ack", ack_irq, 0);

    // R2: graphics busy
    gfx_idle = 1'b0;
    pulse_req(a);
    check("R2 ack", a, 0);
    repeat (5) @(negedge clk);
    check("R2 state", state, 0);
    gfx_idle = 1'b1;

    // R4: audio busy, graphics idle
    aud_idle = 1'b0;
    pulse_req(a);
    check("R4 ack", a, 0);
    repeat (5) @(negedge clk);
    check("R4 state", state, 0);
    aud_idle = 1'b1;

    // R3 / R5 / R7: full entry with display PLL
    for (int i = 0; i < NS; i++) push(i, 1'b0);
    pulse_req(a);
    check("R3 ack", a, 1);
    check("R3 state entering", state, 1);
    check("R3 no strobe with ack", step_go, 0);
    @(negedge clk);
    check("R3 ack one cycle", ack_irq, 0);
    wait_st(2, 200, "R7 deep reached");
    check("R7 rail_on", rail_on, 0);
    check("R7 pll_on", pll_on, 0);
    check("R7 owner", db_aon_own, 1);
    check("R5 all entry steps seen", q_idx.size(), 0);

    // R13: request in deep idle
    pulse_req(a);
    check("R13 ack in deep", a, 0);
    check("R13 state in deep", state, 2);

    // R8: out-of-window write ignored, then upper bound wakes
    db_write(16'h0200);
    check("R8 no wake outside", wake_irq, 0);
    check("R8 state stays deep", state, 2);
    for (int i = NS - 1; i >= 0; i--) push(i, 1'b1);
    db_write(16'h01FF);
    check("R8 wake_irq", wake_irq, 1);
    check("R8 state exiting", state, 3);
    check("R8 rail_on", rail_on, 1);
    @(negedge clk);
    check("R8 wake one cycle", wake_irq, 0);
    wait_st(0, 200, "R10 back to active");
    check("R10 pll_on", pll_on, 1);
    check("R10 owner cleared", db_aon_own, 0);
    check("R10 all exit steps seen", q_idx.size(), 0);

    // R6 / R9: no display PLL, audio wake
    dpll_en = 1'b0;
    push(0, 1'b0); push(1, 1'b0);
    for (int i = 3; i < NS; i++) push(i, 1'b0);
    pulse_req(a);
    check("R6 ack", a, 1);
    dpll_en = 1'b1;
    wait_st(2, 200, "R6 deep reached");
    for (int i = NS - 1; i >= 3; i--) push(i, 1'b1);
    push(1, 1'b1); push(0, 1'b1);
    aud_idle = 1'b0;
    @(negedge clk);
    check("R9 wake_irq", wake_irq, 1);
    check("R9 state exiting", state, 3);
    aud_idle = 1'b1;
    wait_st(0, 200, "R9 back to active");
    check("R6 skip seen both ways", q_idx.size(), 0);

    // R11: doorbell during entry aborts after step 1
    push(0, 1'b0); push(1, 1'b0); push(1, 1'b1); push(0, 1'b1);
    pulse_req(a);
    begin
      int n = 0;
      while (!step_go[1] && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    db_write(16'h0100);
    wait_st(3, 50, "R11 abort to exit");
    wait_st(0, 100, "R11 back to active");
    check("R11 sequence consumed", q_idx.size(), 0);
    check("R11 owner", db_aon_own, 0);
    check("R11 pll_on", pll_on, 1);

    // R12: step that never finishes
    hang = 1'b1;
    push(0, 1'b0);
    pulse_req(a);
    wait_st(4, 60, "R12 error state");
    check("R12 rail_on", rail_on, 1);
    check("R12 pll_on", pll_on, 1);
    pulse_req(a);
    check("R13 ack in error", a, 0);
    check("R13 state in error", state, 4);
    hang = 1'b0;
    wait_st(0, 60, "R12 error clears");
    check("R12 sequence consumed", q_idx.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule